// File: doc/BRIEF.md
# SCSI Target Selection Responder

This block is the target-side sequencer that a controller starts with the opcode 0x0C. Once it is armed, it waits for the bus to select it. It then follows one of two paths, decided by the attention line at the moment of selection. On the first path it takes one message-out byte. On the second it goes straight to the command phase. When it does take a message byte, it chooses between three outcomes:

- It stops and hands the message to the CPU.
- It stops and reports attention that is still held after the identification byte.
- It continues into the command phase.

In the command phase the block takes the length of the command from the group code of its first byte. Every byte it receives is pushed into an external FIFO in arrival order.

While the sequence runs, a status bit stays high. The sequence ends in one of two ways. On success it sets a GOOD flag. If attention is still held after an identification message, it sets a separate attention flag. Either ending leaves the block in target mode, still holding BSY. If the opcode is issued while the controller is already connected, the block raises a command-error flag and lets any sequence in progress run on untouched. The flags are sticky, are ORed onto one interrupt line, and are cleared together by a clear strobe. Bus electrical timing and the later data and status phases belong to other blocks.

Top module: `scsi_tgt_responder`

## Requirements
- R1: During and after reset every output is low: no REQ, no phase lines, no BSY, no FIFO write, status bit low, target mode low, all flags low.
- R2: Opcode 0x0C on `op_valid_i` while not connected arms the block, and `active_o` is high one cycle later. Any other opcode value is ignored and leaves `active_o` and all flags unchanged.
- R3: Opcode 0x0C issued while connected sets `err_flag_o` one cycle later. A sequence already in progress finishes normally. Connected means `link_up_i` is high, or `bsy_o` is high, including in target mode.
- R4: On the cycle `sel_i` is seen, `bsy_o` goes high. If `atn_i` is high at that moment, the block enters message-out (C/D=1, MSG=1, I/O=0). Otherwise it enters the command phase (C/D=1, MSG=0, I/O=0).
- R5: Each byte is taken as follows:
  - REQ is raised with the phase lines driven.
  - The byte on `data_i` is captured when ACK is seen high, and `fifo_wr_o` pulses one cycle later with that byte.
  - REQ drops, and no new REQ is raised until ACK is low again.
  - Bytes reach the FIFO in bus order.
- R6: A message byte with bit 7 clear ends the sequence with GOOD after exactly one byte, with no command phase.
- R7: A message byte with bit 7 set, while `atn_i` is still high after that byte's ACK has dropped, ends the sequence with `satn_flag_o` and no command phase.
- R8: A message byte with bit 7 set, with `atn_i` low after that byte's ACK has dropped, leads into the command phase, which ends with GOOD.
- R9: The command length comes from bits 7:5 of the first command byte:
  - group 0 gives 6 bytes;
  - groups 1 and 2 give 10 bytes;
  - group 5 gives 12 bytes;
  - every other group gives 6 bytes.
- R10: The ending flag appears two cycles after ACK drops on the final byte. In the same cycle `active_o` goes low and `target_mode_o` goes high, and `bsy_o` stays high.
- R11: `irq_o` is high whenever any flag is set. `irq_clr_i` clears all flags. `disconnect_i`, while no sequence runs, drops `bsy_o` and `target_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Opcode strobe from the CPU side |
| op_code_i | input | 8 | Opcode value |
| link_up_i | input | 1 | Controller already connected by another path |
| disconnect_i | input | 1 | Release BSY and leave target mode (idle only) |
| irq_clr_i | input | 1 | Clear all flags |
| sel_i | input | 1 | This target is being selected |
| atn_i | input | 1 | Attention line from the initiator |
| ack_i | input | 1 | ACK from the initiator |
| data_i | input | 8 | Bus data byte |
| req_o | output | 1 | REQ to the initiator |
| cd_o | output | 1 | Control/data phase line |
| msg_o | output | 1 | Message phase line |
| io_o | output | 1 | Direction phase line (low: initiator to target) |
| bsy_o | output | 1 | BSY held by this target |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data |
| active_o | output | 1 | Sequence-running status bit |
| target_mode_o | output | 1 | Ended in target mode |
| good_flag_o | output | 1 | Successful completion flag |
| satn_flag_o | output | 1 | Attention-after-identify flag |
| err_flag_o | output | 1 | Command issued while connected |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency:
- `active_o` and `err_flag_o` change one cycle after the opcode strobe.
- `bsy_o` and REQ rise one cycle after `sel_i`.
- The FIFO strobe follows the cycle in which ACK is captured.
- The ending flags arrive two cycles after the last ACK drops.

The bench drives every input on a falling edge and reads every output on a later falling edge. It counts the falling edges between the last ACK release and the drop of `active_o`, and it requires exactly two. The sweep covers all eight command groups, the three message outcomes, and command-error injection both in idle and in the middle of a command.

// File: rtl/scsi_tgt_pkg.sv
// Shared types for the SCSI target selection responder.
// Assumes: one responder per bus port; all bytes flow initiator to target.
package scsi_tgt_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,  // not running
        SQ_WSEL = 2'd1,  // armed, waiting to be selected
        SQ_MSG  = 2'd2,  // message-out byte transfer
        SQ_CMD  = 2'd3   // command byte transfers
    } seq_state_t;

    // Byte handshake states
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,  // no transfer
        RX_REQ  = 2'd1,  // REQ high, waiting for ACK
        RX_REL  = 2'd2   // REQ low, waiting for ACK release
    } rx_state_t;

    // Ending kinds reported to the flag unit
    typedef struct packed {
        logic good;
        logic satn;
        logic err;
    } flag_set_t;

endpackage

// File: rtl/scsi_tgt_byte_rx.sv
// Receives one byte per start strobe with a REQ/ACK interlock.
// Raises REQ, captures data when ACK is seen high, pushes the byte,
// drops REQ and waits for ACK low, then pulses done.
// Assumes: start_i arrives only while idle.
module scsi_tgt_byte_rx
    import scsi_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          ack_i,
    input  logic [DW-1:0] data_i,
    output logic          req_o,
    output logic          push_o,
    output logic [DW-1:0] byte_o,
    output logic          done_o
);

    rx_state_t     st_q;
    logic [DW-1:0] byte_q;
    logic          push_q;
    logic          done_q;

    // Handshake state, captured byte and one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            byte_q <= '0;
            push_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            push_q <= 1'b0;
            done_q <= 1'b0;
            case (st_q)
                RX_IDLE: if (start_i) st_q <= RX_REQ;
                RX_REQ: begin
                    if (ack_i) begin
                        byte_q <= data_i;
                        push_q <= 1'b1;
                        st_q   <= RX_REL;
                    end
                end
                RX_REL: begin
                    if (!ack_i) begin
                        done_q <= 1'b1;
                        st_q   <= RX_IDLE;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    // REQ is high exactly while waiting for ACK
    assign req_o  = (st_q == RX_REQ);
    assign push_o = push_q;
    assign byte_o = byte_q;
    assign done_o = done_q;

endmodule

// File: rtl/scsi_tgt_len_dec.sv
// Maps a command group code to the command length in bytes.
// Assumes: unknown groups use the short length.
module scsi_tgt_len_dec #(
    parameter int LEN_SHORT = 6,
    parameter int LEN_MID   = 10,
    parameter int LEN_LONG  = 12,
    parameter int CW        = 4
) (
    input  logic [2:0]    grp_i,
    output logic [CW-1:0] len_o
);

    // Group to length lookup
    always_comb begin
        case (grp_i)
            3'd1, 3'd2: len_o = CW'(LEN_MID);
            3'd5:       len_o = CW'(LEN_LONG);
            default:    len_o = CW'(LEN_SHORT);
        endcase
    end

endmodule

// File: rtl/scsi_tgt_flags.sv
// Sticky interrupt flags with a common clear; a set wins over a clear
// in the same cycle. Drives one ORed interrupt line.
module scsi_tgt_flags
    import scsi_tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_set_t set_i,
    input  logic      clr_i,
    output logic      good_o,
    output logic      satn_o,
    output logic      err_o,
    output logic      irq_o
);

    flag_set_t fl_q;

    // Flag storage: clear first, then apply sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            if (clr_i) fl_q <= '0;
            if (set_i.good) fl_q.good <= 1'b1;
            if (set_i.satn) fl_q.satn <= 1'b1;
            if (set_i.err)  fl_q.err  <= 1'b1;
        end
    end

    assign good_o = fl_q.good;
    assign satn_o = fl_q.satn;
    assign err_o  = fl_q.err;
    assign irq_o  = fl_q.good | fl_q.satn | fl_q.err;

endmodule

// File: rtl/scsi_tgt_seq.sv
// Selection and phase sequencer for the target responder.
// Decides between message-out and command paths, counts command bytes
// against the decoded length and reports the ending kind.
// Assumes: len_i is the decode of rx_byte_i's group bits, valid with rx_done_i.
module scsi_tgt_seq
    import scsi_tgt_pkg::*;
#(
    parameter logic [7:0] OPC    = 8'h0C,
    parameter int         ID_BIT = 7,
    parameter int         DW     = 8,
    parameter int         CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid_i,
    input  logic [7:0]    op_code_i,
    input  logic          link_up_i,
    input  logic          disconnect_i,
    input  logic          sel_i,
    input  logic          atn_i,
    input  logic          rx_done_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic [CW-1:0] len_i,
    output logic          rx_start_o,
    output logic          cd_o,
    output logic          msg_o,
    output logic          bsy_o,
    output logic          active_o,
    output logic          tmode_o,
    output flag_set_t     set_o
);

    seq_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic          bsy_q;
    logic          act_q;
    logic          tmode_q;

    logic          issue;
    logic          connected;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] len_eff;
    logic          is_ident;
    logic          fin_good;
    logic          fin_satn;

    // Decode of issue, connection and ending conditions
    always_comb begin
        issue     = op_valid_i && (op_code_i == OPC);
        connected = link_up_i || bsy_q;
        cnt_nx    = cnt_q + CW'(1);
        len_eff   = (cnt_q == '0) ? len_i : len_q;
        is_ident  = rx_byte_i[ID_BIT];
        fin_good  = ((st_q == SQ_MSG) && rx_done_i && !is_ident) ||
                    ((st_q == SQ_CMD) && rx_done_i && (cnt_nx == len_eff));
        fin_satn  = (st_q == SQ_MSG) && rx_done_i && is_ident && atn_i;
        rx_start_o = ((st_q == SQ_WSEL) && sel_i) ||
                     ((st_q == SQ_MSG) && rx_done_i && is_ident && !atn_i) ||
                     ((st_q == SQ_CMD) && rx_done_i && (cnt_nx != len_eff));
    end

    // Sequencer state, byte count and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            bsy_q   <= 1'b0;
            act_q   <= 1'b0;
            tmode_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (issue && !connected) begin
                        st_q  <= SQ_WSEL;
                        act_q <= 1'b1;
                    end else if (disconnect_i) begin
                        bsy_q   <= 1'b0;
                        tmode_q <= 1'b0;
                    end
                end
                SQ_WSEL: begin
                    if (sel_i) begin
                        bsy_q <= 1'b1;
                        cnt_q <= '0;
                        st_q  <= atn_i ? SQ_MSG : SQ_CMD;
                    end
                end
                SQ_MSG: begin
                    if (fin_good || fin_satn) begin
                        st_q    <= SQ_IDLE;
                        act_q   <= 1'b0;
                        tmode_q <= 1'b1;
                    end else if (rx_done_i) begin
                        st_q  <= SQ_CMD;
                        cnt_q <= '0;
                    end
                end
                SQ_CMD: begin
                    if (rx_done_i) begin
                        cnt_q <= cnt_nx;
                        len_q <= len_eff;
                    end
                    if (fin_good) begin
                        st_q    <= SQ_IDLE;
                        act_q   <= 1'b0;
                        tmode_q <= 1'b1;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign cd_o       = (st_q == SQ_MSG) || (st_q == SQ_CMD);
    assign msg_o      = (st_q == SQ_MSG);
    assign bsy_o      = bsy_q;
    assign active_o   = act_q;
    assign tmode_o    = tmode_q;
    assign set_o.good = fin_good;
    assign set_o.satn = fin_satn;
    assign set_o.err  = issue && connected;

endmodule

// File: rtl/scsi_tgt_responder.sv
// Top of the SCSI target selection responder.
// Wires the sequencer, byte handshake, length decoder and flag unit.
// Assumes: selection arbitration is decoded upstream into sel_i.
module scsi_tgt_responder
    import scsi_tgt_pkg::*;
#(
    parameter int         DW        = 8,
    parameter logic [7:0] OPC       = 8'h0C,
    parameter int         ID_BIT    = 7,
    parameter int         LEN_SHORT = 6,
    parameter int         LEN_MID   = 10,
    parameter int         LEN_LONG  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid_i,
    input  logic [7:0]    op_code_i,
    input  logic          link_up_i,
    input  logic          disconnect_i,
    input  logic          irq_clr_i,
    input  logic          sel_i,
    input  logic          atn_i,
    input  logic          ack_i,
    input  logic [DW-1:0] data_i,
    output logic          req_o,
    output logic          cd_o,
    output logic          msg_o,
    output logic          io_o,
    output logic          bsy_o,
    output logic          fifo_wr_o,
    output logic [DW-1:0] fifo_data_o,
    output logic          active_o,
    output logic          target_mode_o,
    output logic          good_flag_o,
    output logic          satn_flag_o,
    output logic          err_flag_o,
    output logic          irq_o
);

    localparam int LEN_A   = (LEN_SHORT > LEN_MID) ? LEN_SHORT : LEN_MID;
    localparam int LEN_MAX = (LEN_A > LEN_LONG) ? LEN_A : LEN_LONG;
    localparam int CW      = $clog2(LEN_MAX + 1);

    logic          rx_start;
    logic          rx_done;
    logic [DW-1:0] rx_byte;
    logic [CW-1:0] len_dec;
    flag_set_t     fl_set;

    scsi_tgt_seq #(
        .OPC(OPC), .ID_BIT(ID_BIT), .DW(DW), .CW(CW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid_i   (op_valid_i),
        .op_code_i    (op_code_i),
        .link_up_i    (link_up_i),
        .disconnect_i (disconnect_i),
        .sel_i        (sel_i),
        .atn_i        (atn_i),
        .rx_done_i    (rx_done),
        .rx_byte_i    (rx_byte),
        .len_i        (len_dec),
        .rx_start_o   (rx_start),
        .cd_o         (cd_o),
        .msg_o        (msg_o),
        .bsy_o        (bsy_o),
        .active_o     (active_o),
        .tmode_o      (target_mode_o),
        .set_o        (fl_set)
    );

    scsi_tgt_byte_rx #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rx_start),
        .ack_i   (ack_i),
        .data_i  (data_i),
        .req_o   (req_o),
        .push_o  (fifo_wr_o),
        .byte_o  (rx_byte),
        .done_o  (rx_done)
    );

    scsi_tgt_len_dec #(
        .LEN_SHORT(LEN_SHORT), .LEN_MID(LEN_MID), .LEN_LONG(LEN_LONG), .CW(CW)
    ) u_len (
        .grp_i (rx_byte[DW-1 -: 3]),
        .len_o (len_dec)
    );

    scsi_tgt_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fl_set),
        .clr_i  (irq_clr_i),
        .good_o (good_flag_o),
        .satn_o (satn_flag_o),
        .err_o  (err_flag_o),
        .irq_o  (irq_o)
    );

    // All transfers run initiator to target
    assign io_o        = 1'b0;
    assign fifo_data_o = rx_byte;

endmodule

// File: rtl/scsi_tgt_responder_chk.sv
// Protocol checker for the responder, bound to the top module.
module scsi_tgt_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic atn_i,
    input logic ack_i,
    input logic req_o,
    input logic cd_o,
    input logic msg_o,
    input logic io_o,
    input logic bsy_o,
    input logic fifo_wr_o,
    input logic active_o,
    input logic target_mode_o,
    input logic good_flag_o,
    input logic satn_flag_o,
    input logic err_flag_o
);

    p_req_in_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (cd_o && !io_o && active_o));

    p_push_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> ($past(ack_i) && $past(req_o)));

    p_bsy_on_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_o) |-> $past(sel_i));

    p_msg_needs_atn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_o) |-> $past(atn_i));

    p_satn_needs_atn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(satn_flag_o) |-> $past(atn_i));

    p_end_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> ((good_flag_o || satn_flag_o) && target_mode_o && bsy_o));

    p_err_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_flag_o) && !$past(active_o)) |-> !active_o);

endmodule

bind scsi_tgt_responder scsi_tgt_responder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (sel_i),
    .atn_i         (atn_i),
    .ack_i         (ack_i),
    .req_o         (req_o),
    .cd_o          (cd_o),
    .msg_o         (msg_o),
    .io_o          (io_o),
    .bsy_o         (bsy_o),
    .fifo_wr_o     (fifo_wr_o),
    .active_o      (active_o),
    .target_mode_o (target_mode_o),
    .good_flag_o   (good_flag_o),
    .satn_flag_o   (satn_flag_o),
    .err_flag_o    (err_flag_o)
);

// File: tb/sim_scsi_tgt_responder.sv
module sim_scsi_tgt_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [7:0] op_code_i = 8'h00;
    logic       link_up_i = 1'b0;
    logic       disconnect_i = 1'b0;
    logic       irq_clr_i = 1'b0;
    logic       sel_i = 1'b0;
    logic       atn_i = 1'b0;
    logic       ack_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       req_o, cd_o, msg_o, io_o, bsy_o, fifo_wr_o;
    logic [7:0] fifo_data_o;
    logic       active_o, target_mode_o, good_flag_o, satn_flag_o, err_flag_o, irq_o;

    int nchk = 0;
    int nerr = 0;
    int ngot = 0;
    logic [7:0] got [0:31];
    logic [7:0] sent [0:31];

    always #10 clk = ~clk;

    scsi_tgt_responder u0 (.*);

    // FIFO write monitor
    always @(negedge clk) begin
        if (rst_n && fifo_wr_o && ngot < 32) begin
            got[ngot] = fifo_data_o;
            ngot++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [2:0] g);
        case (g)
            3'd0:       return 6;
            3'd1, 3'd2: return 10;
            3'd5:       return 12;
            default:    return 6;
        endcase
    endfunction

    function automatic logic [7:0] cmd_byte(input logic [2:0] g, input int k);
        if (k == 0) return {g, 5'h11};
        return 8'((k * 13) + g);
    endfunction

    task automatic housekeep();
        @(negedge clk) irq_clr_i = 1'b1; disconnect_i = 1'b1;
        @(negedge clk) irq_clr_i = 1'b0; disconnect_i = 1'b0;
        chk("R11 irq after clear", irq_o, 0);
        chk("R11 bsy after disconnect", bsy_o, 0);
        chk("R11 target mode after disconnect", target_mode_o, 0);
    endtask

    // One full session; kind 0 = GOOD, 1 = SATN
    task automatic session(input bit atn0, input logic [7:0] mbyte, input bit keep,
                           input logic [2:0] g, input int ncmd, input int kind, input bit inject);
        int nb = 0;
        int nsent = 0;
        int cyc = 0;
        int drop_at = -100;
        int lat = -1;
        housekeep();
        ngot = 0;
        @(negedge clk) op_valid_i = 1'b1; op_code_i = 8'h0C;
        @(negedge clk) op_valid_i = 1'b0;
        chk("R2 active after issue", active_o, 1);
        atn_i = atn0; sel_i = 1'b1;
        @(negedge clk) sel_i = 1'b0;
        chk("R4 bsy after select", bsy_o, 1);
        for (int i = 0; i < 400; i++) begin
            cyc++;
            op_valid_i = 1'b0;
            if (!active_o) begin
                lat = cyc - drop_at;
                break;
            end
            if (req_o && !ack_i) begin
                chk("R4 cd line", cd_o, 1);
                chk("R4 io line", io_o, 0);
                chk("R4 msg line", msg_o, (atn0 && nb == 0) ? 1 : 0);
                data_i = (atn0 && nb == 0) ? mbyte : cmd_byte(g, nb - (atn0 ? 1 : 0));
                sent[nsent] = data_i; nsent++;
                ack_i = 1'b1;
                nb++;
                if (inject && nb == 3) begin
                    op_valid_i = 1'b1; op_code_i = 8'h0C;
                end
            end else if (!req_o && ack_i) begin
                ack_i = 1'b0;
                drop_at = cyc;
                if (atn0 && nb == 1 && !keep) atn_i = 1'b0;
            end
            @(negedge clk);
        end
        atn_i = 1'b0;
        chk("R10 flag latency after last ACK", lat, 2);
        chk("R9 byte count", ngot, (atn0 ? 1 : 0) + ncmd);
        for (int k = 0; k < nsent && k < 32; k++)
            chk("R5 fifo byte order", got[k], sent[k]);
        chk("R6 R8 good flag", good_flag_o, kind == 0 ? 1 : 0);
        chk("R7 satn flag", satn_flag_o, kind == 1 ? 1 : 0);
        chk("R3 err flag", err_flag_o, inject ? 1 : 0);
        chk("R10 target mode", target_mode_o, 1);
        chk("R10 bsy held", bsy_o, 1);
        chk("R11 irq line", irq_o, 1);
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", req_o, 0);
        chk("R1 active in reset", active_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bsy after reset", bsy_o, 0);
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 target mode after reset", target_mode_o, 0);
        chk("R1 phase lines after reset", {cd_o, msg_o, io_o, fifo_wr_o}, 0);

        // R2: other opcode ignored
        @(negedge clk) op_valid_i = 1'b1; op_code_i = 8'h0D;
        @(negedge clk) op_valid_i = 1'b0;
        chk("R2 other opcode active", active_o, 0);
        chk("R2 other opcode irq", irq_o, 0);

        // R3: issue while linked elsewhere
        link_up_i = 1'b1;
        @(negedge clk) op_valid_i = 1'b1; op_code_i = 8'h0C;
        @(negedge clk) op_valid_i = 1'b0;
        chk("R3 err while connected", err_flag_o, 1);
        chk("R3 no start while connected", active_o, 0);
        link_up_i = 1'b0;

        // R9: sweep all groups, no attention
        for (int g = 0; g < 8; g++)
            session(1'b0, 8'h00, 1'b0, 3'(g), exp_len(3'(g)), 0, 1'b0);

        // R3: issue while held in target mode
        @(negedge clk) op_valid_i = 1'b1; op_code_i = 8'h0C;
        @(negedge clk) op_valid_i = 1'b0;
        chk("R3 err in target mode", err_flag_o, 1);
        chk("R3 no restart in target mode", active_o, 0);

        // R6: non-identify message
        session(1'b1, 8'h05, 1'b1, 3'd0, 0, 0, 1'b0);
        // R7: identify with attention held
        session(1'b1, 8'hC0, 1'b1, 3'd0, 0, 1, 1'b0);
        // R8: identify then command, two groups
        session(1'b1, 8'h80, 1'b0, 3'd5, 12, 0, 1'b0);
        session(1'b1, 8'h81, 1'b0, 3'd2, 10, 0, 1'b0);
        // R3: issue during command phase
        session(1'b0, 8'h00, 1'b0, 3'd1, 10, 0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule